// File: doc/BRIEF.md
# Sticky-Rounding Barrel Shifter

This block shifts a 16-bit operand left or right by any count from 0 to 31. A right shift can be logical, which fills with zeros, or arithmetic, which copies the sign bit into the vacated positions. The operation completes in one clock. The result is registered together with five condition flags: carry, sticky, negative, overflow and zero.

On a right shift, carry and sticky together describe the bits that fell off the bottom of the operand. Rounding logic downstream can use them without seeing the discarded bits:

| Carry | Sticky | Discarded fraction |
|-------|--------|--------------------|
| 0 | 0 | zero |
| 0 | 1 | above zero and below half an LSB |
| 1 | 0 | exactly half an LSB |
| 1 | 1 | above half and below one LSB |

A request is a single cycle with `in_valid` high. The outputs load on the next rising edge, and `out_valid` marks them. Reset is synchronous and active high.

Top module: `sticky_barrel_shifter`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `out_valid` is high and the outputs hold that request's results. After a cycle with `in_valid` low, `out_valid` is low and every other output keeps its previous value. Reset drives all outputs to 0.
- R2: With `dir_right` = 0, `result` is `operand` shifted left by `count`, zero filled, so a count of 16 or more gives 0. `arith` has no effect on left shifts.
- R3: With `dir_right` = 1, `result` is `operand` shifted right by `count`. When `arith` = 0 the vacated bits are 0. When `arith` = 1 they copy `operand[15]`, so a count of 16 or more gives all copies of that bit.
- R4: `flag_c` is the last bit moved out of the operand.
  - On a left shift by k (1 ≤ k ≤ 16) it is `operand[16-k]`, and it is 0 for k > 16.
  - On a right shift by k it is bit k-1 of the fill-extended operand, so for k > 16 it equals the fill bit.
- R5: On a right shift by k ≥ 2, `flag_st` is the OR of bits k-2 down to 0 of the fill-extended operand. These are the bits that passed through carry and were dropped. `flag_st` is 0 for k ≤ 1 and for every left shift.
- R6: On a right shift by k ≥ 1, the pair {`flag_c`,`flag_st`} as a 2-bit code classifies the discarded value f, which is the low k bits of the fill-extended operand, against half = 2^(k-1):
  - 0 when f = 0;
  - 1 when 0 < f < half;
  - 2 when f = half;
  - 3 when f > half.
- R7: `flag_n` equals `result[15]` for every shift, including a count of zero.
- R8: `flag_v` is set when the most significant bit held after any single step of the shift differs from `operand[15]`. So a logical right shift sets it exactly when `operand[15]` = 1 and the count is non-zero. An arithmetic right shift never sets it. A left shift sets it when any of the bits moved through bit 15, zeros beyond the operand included, differs from `operand[15]`.
- R9: `flag_z` is 1 exactly when `result` is 0.
- R10: A count of 0 returns `operand` unchanged with `flag_c`, `flag_st` and `flag_v` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 16 | Value to shift |
| count | input | 5 | Shift distance, 0 to 31 |
| dir_right | input | 1 | 1 = right shift, 0 = left shift |
| arith | input | 1 | 1 = sign fill on right shifts |
| out_valid | output | 1 | Results below are fresh |
| result | output | 16 | Shifted value |
| flag_c | output | 1 | Last bit shifted out |
| flag_st | output | 1 | A 1 passed through carry and was lost |
| flag_n | output | 1 | Result MSB |
| flag_v | output | 1 | MSB changed during the shift |
| flag_z | output | 1 | Result is zero |

## Verification
The result and all five flags come from a single register stage, so they are due on the first rising edge after the request. The bench applies each request at a falling edge and reads the outputs at the next falling edge, half a period after that register loads. After the last request it drops `in_valid` and reads again one falling edge later, to confirm that `out_valid` has cleared and the held values have not moved. Every count from 0 to 31 is swept in all four direction/fill combinations over a set of edge and pseudo-random operands. Expected values come from wide integer shifts and from a direct comparison of the discarded fraction against half an LSB.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    KIND_LEFT      = 2'd0,
    KIND_RIGHT_LOG = 2'd1,
    KIND_RIGHT_ARI = 2'd2
  } shift_kind_e;

  typedef struct packed {
    logic c;
    logic st;
    logic n;
    logic v;
    logic z;
  } shift_flags_t;

  function automatic shift_kind_e decode_kind(input logic right, input logic ar);
    if (!right)  return KIND_LEFT;
    else if (ar) return KIND_RIGHT_ARI;
    else         return KIND_RIGHT_LOG;
  endfunction

endpackage

// File: rtl/bshift_stage.sv
// One power-of-two step of the right-shifting datapath. It tracks the
// last bit dropped (carry) and whether any earlier dropped bit was a one.
module bshift_stage #(
  parameter int W = 16,
  parameter int S = 1
) (
  input  logic         en,
  input  logic         fill,
  input  logic [W-1:0] d_in,
  input  logic         c_in,
  input  logic         st_in,
  output logic [W-1:0] d_out,
  output logic         c_out,
  output logic         st_out
);
  localparam int EW = W + S;

  logic [EW-1:0] ext;
  logic          low_any;

  assign ext = {{S{fill}}, d_in};

  generate
    if (S == 1) begin : g_single
      assign low_any = 1'b0;
    end else begin : g_multi
      assign low_any = |ext[S-2:0];
    end
  endgenerate

  always_comb begin
    if (en) begin
      d_out  = ext[EW-1:S];
      c_out  = ext[S-1];
      st_out = st_in | c_in | low_any;
    end else begin
      d_out  = d_in;
      c_out  = c_in;
      st_out = st_in;
    end
  end
endmodule

// File: rtl/bshift_ovf.sv
// Walks every single-bit step of the shift and flags any change of the
// top bit relative to the operand's original top bit.
module bshift_ovf #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  operand,
  input  logic [CW-1:0] count,
  input  logic          right,
  input  logic          fill,
  output logic          ovf
);
  localparam int MAXC = (1 << CW) - 1;

  always_comb begin
    logic msb_j;
    ovf = 1'b0;
    for (int j = 1; j <= MAXC; j++) begin
      if (right)       msb_j = fill;
      else if (j < W)  msb_j = operand[W-1-j];
      else             msb_j = 1'b0;
      if ((j <= int'(count)) && (msb_j != operand[W-1])) ovf = 1'b1;
    end
  end
endmodule

// File: rtl/bshift_core.sv
// Logarithmic shifter. A left shift is done as a right shift of the
// bit-reversed operand, so both directions share one stage chain.
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  operand,
  input  logic [CW-1:0] count,
  input  shift_kind_e   kind,
  output logic [W-1:0]  res,
  output logic          carry,
  output logic          sticky
);
  logic            right;
  logic            fill;
  logic [W-1:0]    src;
  logic [W-1:0]    d   [CW+1];
  logic            c   [CW+1];
  logic            st  [CW+1];

  assign right = (kind != KIND_LEFT);
  assign fill  = (kind == KIND_RIGHT_ARI) ? operand[W-1] : 1'b0;

  always_comb begin
    for (int i = 0; i < W; i++) src[i] = right ? operand[i] : operand[W-1-i];
  end

  assign d[0]  = src;
  assign c[0]  = 1'b0;
  assign st[0] = 1'b0;

  generate
    for (genvar g = 0; g < CW; g++) begin : g_stage
      bshift_stage #(.W(W), .S(1 << g)) u_stage (
        .en    (count[g]),
        .fill  (fill),
        .d_in  (d[g]),
        .c_in  (c[g]),
        .st_in (st[g]),
        .d_out (d[g+1]),
        .c_out (c[g+1]),
        .st_out(st[g+1])
      );
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < W; i++) res[i] = right ? d[CW][i] : d[CW][W-1-i];
    carry  = c[CW];
    sticky = right ? st[CW] : 1'b0;
  end
endmodule

// File: rtl/sticky_barrel_shifter.sv
module sticky_barrel_shifter
  import bshift_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  operand,
  input  logic [CW-1:0] count,
  input  logic          dir_right,
  input  logic          arith,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          flag_c,
  output logic          flag_st,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z
);
  shift_kind_e  kind;
  logic [W-1:0] res_d;
  logic         carry_d;
  logic         sticky_d;
  logic         ovf_d;
  logic         fill;
  shift_flags_t flags_d;

  assign kind = decode_kind(dir_right, arith);
  assign fill = (kind == KIND_RIGHT_ARI) ? operand[W-1] : 1'b0;

  bshift_core #(.W(W), .CW(CW)) u_core (
    .operand(operand),
    .count  (count),
    .kind   (kind),
    .res    (res_d),
    .carry  (carry_d),
    .sticky (sticky_d)
  );

  bshift_ovf #(.W(W), .CW(CW)) u_ovf (
    .operand(operand),
    .count  (count),
    .right  (dir_right),
    .fill   (fill),
    .ovf    (ovf_d)
  );

  always_comb begin
    flags_d.c  = carry_d;
    flags_d.st = sticky_d;
    flags_d.n  = res_d[W-1];
    flags_d.v  = ovf_d;
    flags_d.z  = (res_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_c    <= 1'b0;
      flag_st   <= 1'b0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_d;
        flag_c  <= flags_d.c;
        flag_st <= flags_d.st;
        flag_n  <= flags_d.n;
        flag_v  <= flags_d.v;
        flag_z  <= flags_d.z;
      end
    end
  end
endmodule

// File: rtl/sticky_barrel_shifter_checker.sv
module sticky_barrel_shifter_checker #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  operand,
  input logic [CW-1:0] count,
  input logic          dir_right,
  input logic          arith,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          flag_c,
  input logic          flag_st,
  input logic          flag_n,
  input logic          flag_v,
  input logic          flag_z
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_left_no_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir_right) |=> !flag_st);

  assert_one_step_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir_right && count == 1) |=> !flag_st);

  assert_neg_is_msb_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_n == result[W-1]));

  assert_arith_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir_right && arith) |=> !flag_v);

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_z == (result == '0)));

  assert_zero_count_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count == 0) |=>
      (result == $past(operand) && !flag_c && !flag_st && !flag_v));
endmodule

bind sticky_barrel_shifter sticky_barrel_shifter_checker #(.W(W), .CW(CW)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .operand  (operand),
  .count    (count),
  .dir_right(dir_right),
  .arith    (arith),
  .out_valid(out_valid),
  .result   (result),
  .flag_c   (flag_c),
  .flag_st  (flag_st),
  .flag_n   (flag_n),
  .flag_v   (flag_v),
  .flag_z   (flag_z)
);

// File: tb/sticky_barrel_shifter_bench.sv
`timescale 1ns/1ps
module sticky_barrel_shifter_bench;
  localparam int  W      = 16;
  localparam int  CW     = 5;
  localparam int  NOPS   = 48;
  localparam real HALF_T = 2.5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  operand = '0;
  logic [CW-1:0] count = '0;
  logic          dir_right = 1'b0;
  logic          arith = 1'b0;
  logic          out_valid;
  logic [W-1:0]  result;
  logic          flag_c, flag_st, flag_n, flag_v, flag_z;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(HALF_T) clk = ~clk;

  sticky_barrel_shifter #(.W(W), .CW(CW)) u_sticky_barrel_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand), .count(count),
    .dir_right(dir_right), .arith(arith), .out_valid(out_valid), .result(result),
    .flag_c(flag_c), .flag_st(flag_st), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (op=%h cnt=%0d right=%0b ar=%0b)",
               req, act, exp, operand, count, dir_right, arith);
    end
  endtask

  function automatic logic [W-1:0] op_of(input int idx);
    logic [W-1:0] lf;
    case (idx)
      0: return 16'h0000;  1: return 16'hFFFF;  2: return 16'h8000;
      3: return 16'h0001;  4: return 16'h7FFF;  5: return 16'h8001;
      6: return 16'hAAAA;  7: return 16'h5555;
      default: begin
        if (idx < 24) return 16'h0001 << (idx - 8);
        lf = 16'hACE1;
        for (int s = 0; s < (idx - 23) * 7; s++)
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf;
      end
    endcase
  endfunction

  task automatic run_one(input logic [W-1:0] op, input int k, input bit rt, input bit ar);
    longint ext, full, frac, half, exp_res;
    bit     e_c, e_st, e_v, msb;
    int     cls;
    @(negedge clk);
    in_valid = 1'b1; operand = op; count = CW'(k); dir_right = rt; arith = ar;
    ext = (rt && ar) ? longint'($signed(op)) : longint'(op);
    if (rt) begin
      full    = ext >>> k;
      exp_res = full & 64'hFFFF;
      e_c     = (k == 0) ? 1'b0 : bit'((ext >>> (k - 1)) & 1);
      e_st    = (k <= 1) ? 1'b0 : ((ext & ((64'sd1 <<< (k - 1)) - 1)) != 0);
    end else begin
      full    = ext << k;
      exp_res = full & 64'hFFFF;
      e_c     = (k == 0) ? 1'b0 : bit'((full >> 16) & 1);
      e_st    = 1'b0;
    end
    e_v = 1'b0;
    for (int j = 1; j <= k; j++) begin
      msb = rt ? bit'((ext >>> (j + 15)) & 1) : bit'(((ext << j) >> 15) & 1);
      if (msb != op[15]) e_v = 1'b1;
    end
    @(negedge clk);
    check("R1 out_valid", longint'(out_valid), 1);
    if (rt) check(ar ? "R3 arith result" : "R3 logical result", longint'(result), exp_res);
    else    check("R2 left result", longint'(result), exp_res);
    check("R4 carry", longint'(flag_c), longint'(e_c));
    check("R5 sticky", longint'(flag_st), longint'(e_st));
    check("R7 negative", longint'(flag_n), longint'(exp_res[15]));
    check("R8 overflow", longint'(flag_v), longint'(e_v));
    check("R9 zero", longint'(flag_z), longint'(exp_res == 0));
    if (rt && k >= 1) begin
      frac = ext & ((64'sd1 <<< k) - 1);
      half = 64'sd1 <<< (k - 1);
      cls  = (frac == 0) ? 0 : (frac < half) ? 1 : (frac == half) ? 2 : 3;
      check("R6 round class", longint'({flag_c, flag_st}), longint'(cls));
    end
    if (k == 0) begin
      check("R10 zero count result", longint'(result), longint'(op));
      check("R10 zero count flags", longint'({flag_c, flag_st, flag_v}), 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(out_valid), 0);
    check("R1 reset result", longint'(result), 0);
    check("R1 reset flags", longint'({flag_c, flag_st, flag_n, flag_v, flag_z}), 0);
    rst = 1'b0;
    for (int i = 0; i < NOPS; i++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 32; k++)
          run_one(op_of(i), k, bit'(m[1]), bit'(m[0]));
    held = result;
    @(negedge clk);
    in_valid = 1'b0; operand = 16'h1234; count = 5'd3;
    @(negedge clk);
    check("R1 idle valid", longint'(out_valid), 0);
    check("R1 idle hold", longint'(result), longint'(held));
    done = 1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule